// File: doc/BRIEF.md
# Periodic Compare Gate Generator

This block watches a free-running 32-bit base count that it shares with other logic and derives a square gate from it. When the block is enabled it arms an internal compare value one period ahead of the count it sees. Each time the count reaches the compare value, the gate flips, a one-cycle match pulse is given, and the compare value moves forward by exactly one period. Because the next target comes from the old target plus a constant, and not from a counter restart, the gate edges never drift relative to the base count.

The control is a two-state machine. In `IDLE` the gate is held low and no compares happen. The transition `ARM` (IDLE to RUN, taken when `enable` is high) loads the compare value. In `RUN` every match toggles the gate. The transition `HALT` (RUN to IDLE, taken when `enable` is low) drops the gate low on the same edge. The period is the parameter `TICKS_PER_SEC`, which defaults to 50,000,000 for a 50 MHz base clock.

Top module: `gate_toggler`

## Requirements
- R1: After reset, `gate_out` and `match_pulse` are both 0 and the machine is in `IDLE`.
- R2: In `IDLE` with `enable` high at a clock edge, the compare value becomes `base_count + TICKS_PER_SEC` (mod 2^32) and the machine enters `RUN`. The first match therefore happens TICKS_PER_SEC edges later if the count steps by one each cycle.
- R3: In `RUN` with `enable` high, at an edge where `base_count` equals the compare value, `gate_out` inverts. It does not change at any other edge, except the drop to 0 described in R7.
- R4: `match_pulse` is 1 for exactly the cycle after an edge with a match and is 0 otherwise.
- R5: Each match advances the compare value by `TICKS_PER_SEC`. A count stepping by one each cycle gives pulses exactly `TICKS_PER_SEC` cycles apart.
- R6: All compare arithmetic wraps modulo 2^32, so a target beyond 0xFFFFFFFF matches after the count wraps.
- R7: While `enable` is low, `gate_out` is held at 0 from the next edge on and no match pulse occurs.
- R8: Raising `enable` again after a `HALT` re-arms the compare value from the count present at that edge (R2 applies afresh).
- R9: A count that stays at the compare value for several cycles produces only one match, because the compare value has already moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low holds the gate low |
| base_count | input | 32 | Shared free-running base count |
| gate_out | output | 1 | Gate level, active high, starts low |
| match_pulse | output | 1 | One-cycle pulse per compare match |

## Verification
A wrong compare value shows at the ports as a first pulse or a pulse interval that is off by a number of cycles. This becomes visible within one period of arming, or one period after the last good match. A stuck or mis-decoded state shows within a cycle of an `enable` change, as a gate that is not forced low or pulses that appear while disabled. Wrap errors appear only when the target crosses 0xFFFFFFFF, so the count is preset just below the wrap point before arming.

// File: rtl/gate_toggler_pkg.sv
package gate_toggler_pkg;
    localparam int unsigned CNT_W = 32;

    typedef enum logic {
        GT_IDLE = 1'b0,
        GT_RUN  = 1'b1
    } gt_state_e;
endpackage

// File: rtl/gt_ctrl.sv
module gt_ctrl
    import gate_toggler_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    output gt_state_e state_q,
    output logic      load_cmp,
    output logic      run_en
);
    gt_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_cmp = 1'b0;
        run_en   = 1'b0;
        unique case (state_q)
            GT_IDLE: begin
                if (enable) begin
                    load_cmp = 1'b1;
                    state_d  = GT_RUN;
                end
            end
            GT_RUN: begin
                if (enable) run_en  = 1'b1;
                else        state_d = GT_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/gt_cmp.sv
module gt_cmp
    import gate_toggler_pkg::*;
#(
    parameter int unsigned TICKS = 50_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_cmp,
    input  logic             run_en,
    input  logic [CNT_W-1:0] base_count,
    output logic [CNT_W-1:0] cmp_q,
    output logic             hit
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(TICKS);

    assign hit = run_en && (base_count == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (load_cmp) cmp_q <= base_count + STEP;
        else if (hit)      cmp_q <= cmp_q + STEP;
    end
endmodule

// File: rtl/gt_out.sv
module gt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic hit,
    output logic gate_q,
    output logic pulse_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
            if (!run_en)  gate_q <= 1'b0;
            else if (hit) gate_q <= ~gate_q;
        end
    end
endmodule

// File: rtl/gate_toggler.sv
module gate_toggler
    import gate_toggler_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [31:0] base_count,
    output logic        gate_out,
    output logic        match_pulse
);
    gt_state_e        state_q;
    logic             load_cmp;
    logic             run_en;
    logic             hit;
    logic [CNT_W-1:0] cmp_q;

    gt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .state_q  (state_q),
        .load_cmp (load_cmp),
        .run_en   (run_en)
    );

    gt_cmp #(.TICKS(TICKS_PER_SEC)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cmp   (load_cmp),
        .run_en     (run_en),
        .base_count (base_count),
        .cmp_q      (cmp_q),
        .hit        (hit)
    );

    gt_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .hit     (hit),
        .gate_q  (gate_out),
        .pulse_q (match_pulse)
    );
endmodule

// File: rtl/gate_toggler_chk.sv
module gate_toggler_chk
    import gate_toggler_pkg::*;
#(
    parameter int unsigned TICKS = 50_000_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [31:0]      base_count,
    input logic             gate_out,
    input logic             match_pulse,
    input gt_state_e        state_q,
    input logic [CNT_W-1:0] cmp_q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(TICKS);

    // R2 / R6: arming loads count plus one period, wrapped to 32 bits
    p_arm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GT_IDLE && enable) |=> (cmp_q == $past(base_count) + STEP));

    // R3: a pulse always accompanies a gate inversion
    p_toggle_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (gate_out != $past(gate_out)));

    // R3: the gate rises only together with a match pulse
    p_rise_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> match_pulse);

    // R5: each match moves the target forward by one period
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (cmp_q == $past(cmp_q) + STEP));

    // R7: disabled means gate low at the next edge and no pulse
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_out && !match_pulse));

    // R4: a pulse needs a running machine on the previous edge
    p_pulse_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(state_q) == GT_RUN && $past(enable)));
endmodule

bind gate_toggler gate_toggler_chk #(.TICKS(TICKS_PER_SEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .base_count  (base_count),
    .gate_out    (gate_out),
    .match_pulse (match_pulse),
    .state_q     (state_q),
    .cmp_q       (cmp_q)
);

// File: tb/gate_toggler_tb.sv
module gate_toggler_tb;
    localparam int unsigned P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] cnt = 32'd100;
    logic        gate_out;
    logic        match_pulse;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int npulse = 0;
    int last_pulse = -1;
    int first_pulse = -1;
    int gap_bad = 0;
    int inc = 1;

    // behavioural reference state
    bit          m_run = 0;
    bit          m_gate = 0;
    bit          m_pulse = 0;
    logic [31:0] m_cmp = 0;

    always #4 clk = ~clk;

    gate_toggler #(.TICKS_PER_SEC(P)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .base_count  (cnt),
        .gate_out    (gate_out),
        .match_pulse (match_pulse)
    );

    always @(posedge clk) begin
        bit p;
        p = 0;
        if (!rst_n) begin
            m_run = 0; m_gate = 0; m_cmp = 0;
        end else if (!m_run) begin
            m_gate = 0;
            if (enable) begin m_cmp = cnt + P; m_run = 1; end
        end else if (!enable) begin
            m_run = 0; m_gate = 0;
        end else if (cnt == m_cmp) begin
            m_gate = ~m_gate; p = 1; m_cmp = m_cmp + P;
        end
        m_pulse = p;
    end

    task automatic check(string tag, bit cond, int act, int exp);
        checks++;
        if (!cond) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(string tag);
        @(negedge clk);
        cyc++;
        check({tag, " gate"}, gate_out === m_gate, int'(gate_out), int'(m_gate));
        check({tag, " pulse"}, match_pulse === m_pulse, int'(match_pulse), int'(m_pulse));
        if (match_pulse === 1'b1) begin
            npulse++;
            if (first_pulse < 0) first_pulse = cyc;
            if (last_pulse >= 0 && cyc - last_pulse != int'(P)) gap_bad++;
            last_pulse = cyc;
        end
        cnt = cnt + 32'(inc);
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int en_cyc;
        // R1 reset state
        repeat (3) tick("R1");
        check("R1 reset gate/pulse", gate_out === 1'b0 && match_pulse === 1'b0,
              int'({gate_out, match_pulse}), 0);
        rst_n = 1'b1;

        // R7 disabled: no activity
        npulse = 0;
        repeat (2 * P) tick("R7");
        check("R7 no pulse while disabled", npulse == 0, npulse, 0);

        // R2/R3/R4/R5 normal run
        enable = 1'b1; en_cyc = cyc; npulse = 0; first_pulse = -1; last_pulse = -1; gap_bad = 0;
        repeat (4 * P + 5) tick("R3");
        check("R2 first match delay", first_pulse - en_cyc == int'(P) + 1, first_pulse - en_cyc, int'(P) + 1);
        check("R5 pulse spacing", gap_bad == 0, gap_bad, 0);
        check("R4 pulse count", npulse == 4, npulse, 4);

        // R7 disable mid-run: gate forced low
        enable = 1'b0; npulse = 0;
        tick("R7");
        check("R7 gate low after disable", gate_out === 1'b0, int'(gate_out), 0);
        repeat (2 * P) tick("R7");
        check("R7 no pulse after disable", npulse == 0, npulse, 0);

        // R6 wrap, also R8 re-arm from current count
        cnt = 32'hFFFF_FFF8;
        tick("R6");
        enable = 1'b1; en_cyc = cyc; npulse = 0; first_pulse = -1; last_pulse = -1; gap_bad = 0;
        repeat (3 * P) tick("R6");
        check("R6 pulses across wrap", npulse == 2, npulse, 2);
        check("R8 re-arm delay", first_pulse - en_cyc == int'(P) + 1, first_pulse - en_cyc, int'(P) + 1);
        check("R6 spacing across wrap", gap_bad == 0, gap_bad, 0);

        // R9 count stalls on the target
        while (cnt != m_cmp) tick("R9");
        inc = 0; npulse = 0;
        repeat (6) tick("R9");
        check("R9 single match on stall", npulse == 1, npulse, 1);
        inc = 1;
        repeat (P) tick("R9");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule